// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Access Rights

This block turns a 32-bit virtual address into a physical address. It uses a small, fully associative cache of page mappings. The page offset (low 12 bits) passes through unchanged. The upper 20 bits form the virtual page number, which is compared against every stored tag in parallel. A matching slot supplies a 20-bit physical page number. Each slot also holds a read right and a write right. A lookup whose access type is not allowed by the matching slot is reported as a protection fault, and no address is given.

When a lookup misses, an external page walker reads the page table and installs the mapping through the fill port. The block chooses the slot to overwrite by itself. It takes the lowest-numbered empty slot. If every slot is valid, it takes the lowest slot whose recently-used mark is clear. If every mark is set, all marks are cleared first and slot 0 is taken.

Each slot keeps two status bits:
- a modified mark, set by a permitted write hit;
- a recently-used mark, set by any permitted hit.

When a fill overwrites a valid slot, the block reports the evicted page and its modified mark, so the caller knows whether the page must be written back. A flush input drops every mapping in one cycle.

Top module: `va_xlate_tlb`

## Requirements
- R1: A lookup that hits with the access allowed raises `res_hit` on the next cycle. `res_paddr` then equals the slot's physical page number in bits 31..12, followed by the lookup's unchanged bits 11..0.
- R2: A lookup whose page number matches no valid slot raises `res_miss` on the next cycle. Exactly one of `res_hit`, `res_miss` and `res_fault` is high whenever `res_valid` is high. After reset no slot is valid.
- R3: A read lookup (`lk_write`=0) that matches a slot without read right raises `res_fault`, keeps `res_hit` low and drives `res_paddr` to zero.
- R4: A write lookup (`lk_write`=1) that matches a slot without write right raises `res_fault`, keeps `res_hit` low and drives `res_paddr` to zero.
- R5: A permitted write hit sets the slot's modified mark. Fills and read hits leave it clear. The mark appears on `ev_dirty` when the slot is later evicted.
- R6: While any slot is empty, a fill writes the lowest-numbered empty slot. `ev_slot` reports that slot one cycle after the fill.
- R7: When all slots are valid and some recently-used mark is clear, a fill writes the lowest-numbered slot whose mark is clear.
- R8: When all slots are valid and all recently-used marks are set, a fill clears every mark and writes slot 0. A filled slot starts with its recently-used mark set.
- R9: A permitted hit sets the slot's recently-used mark.
- R10: `flush` invalidates every slot in one cycle. Lookups after it miss, and the next fill goes to slot 0 with no eviction reported.
- R11: A faulting lookup changes neither the modified mark nor the recently-used mark of the matching slot.
- R12: One cycle after a fill, `ev_valid` is high only if the overwritten slot was valid. When it is high, `ev_vpn` carries the overwritten page number and `ev_dirty` its modified mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all slots |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup access type, 1 = write, 0 = read |
| lk_vaddr | input | 32 | Virtual address to translate |
| fill_valid | input | 1 | Install a mapping |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Read right of the new mapping |
| fill_wr | input | 1 | Write right of the new mapping |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | Permitted translation |
| res_miss | output | 1 | No valid slot matched |
| res_fault | output | 1 | Access rights violated |
| res_paddr | output | 32 | Physical address, zero unless hit |
| ev_valid | output | 1 | Fill overwrote a valid slot |
| ev_dirty | output | 1 | Overwritten slot was modified |
| ev_vpn | output | 20 | Overwritten page number |
| ev_slot | output | $clog2(ENTRIES) | Slot written by the last fill |

## Verification
Every result appears exactly one clock edge after the request that causes it. The bench drives a lookup or a fill on a falling edge and samples on the following falling edge. By then the result register has been loaded once and no second request has reached it. Status-bit effects (modified mark, recently-used mark, fault side effects) cannot be seen directly at the ports. They are observed at a later fill, through the reported slot and `ev_dirty`. The bench plans each eviction so that the slot and mark it expects follow from the earlier accesses alone.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;
    parameter int OFF_W = 12;
    parameter int VPN_W = 20;
    parameter int PPN_W = 20;
    parameter int VA_W  = VPN_W + OFF_W;
    parameter int PA_W  = PPN_W + OFF_W;

    typedef struct packed {
        logic             vld;
        logic             dirty;
        logic             used;
        logic             rd_ok;
        logic             wr_ok;
        logic [VPN_W-1:0] tag;
        logic [PPN_W-1:0] ppn;
    } slot_t;
endpackage

// File: rtl/va_xlate_match.sv
module va_xlate_match
    import va_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  slot_t            slots [ENTRIES],
    input  logic [VPN_W-1:0] vpn,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [ENTRIES-1:0] eq_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq_vec[g] = slots[g].vld && (slots[g].tag == vpn);
    end

    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq_vec[i]) idx = IDX_W'(i);
        end
        hit = |eq_vec;
    end
endmodule

// File: rtl/va_xlate_victim.sv
module va_xlate_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] vld_vec,
    input  logic [ENTRIES-1:0] used_vec,
    output logic [IDX_W-1:0]   slot,
    output logic               sweep
);
    logic [IDX_W-1:0] free_idx, cold_idx;
    logic             any_free, any_cold;

    always_comb begin
        free_idx = '0;
        cold_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i])  free_idx = IDX_W'(i);
            if (!used_vec[i]) cold_idx = IDX_W'(i);
        end
        any_free = ~&vld_vec;
        any_cold = ~&used_vec;
        sweep    = !any_free && !any_cold;
        if (any_free)      slot = free_idx;
        else if (any_cold) slot = cold_idx;
        else               slot = '0;
    end

    // R6
    free_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~&vld_vec) |-> !vld_vec[slot]);
    // R7
    cold_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&vld_vec) && (~&used_vec)) |-> !used_vec[slot]);
endmodule

// File: rtl/va_xlate_tlb.sv
module va_xlate_tlb
    import va_xlate_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_rd,
    input  logic             fill_wr,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_miss,
    output logic             res_fault,
    output logic [PA_W-1:0]  res_paddr,
    output logic             ev_valid,
    output logic             ev_dirty,
    output logic [VPN_W-1:0] ev_vpn,
    output logic [IDX_W-1:0] ev_slot
);
    typedef struct packed {
        logic             rv;
        logic             hit;
        logic             miss;
        logic             fault;
        logic [PA_W-1:0]  paddr;
        logic             evv;
        logic             evd;
        logic [VPN_W-1:0] evn;
        logic [IDX_W-1:0] evs;
    } out_t;

    slot_t slot_d [ENTRIES];
    slot_t slot_q [ENTRIES];
    out_t  out_d, out_q;

    logic [ENTRIES-1:0] vld_vec, used_vec;
    logic               m_hit;
    logic [IDX_W-1:0]   m_idx;
    logic [IDX_W-1:0]   vic_idx;
    logic               sweep;
    slot_t              m_slot;
    logic               allowed;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_vec
        assign vld_vec[g]  = slot_q[g].vld;
        assign used_vec[g] = slot_q[g].used;
    end

    va_xlate_match #(.ENTRIES(ENTRIES)) u_match (
        .slots (slot_q),
        .vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .hit   (m_hit),
        .idx   (m_idx)
    );

    va_xlate_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld_vec  (vld_vec),
        .used_vec (used_vec),
        .slot     (vic_idx),
        .sweep    (sweep)
    );

    always_comb begin
        slot_d  = slot_q;
        out_d   = '0;
        m_slot  = slot_q[m_idx];
        allowed = lk_write ? m_slot.wr_ok : m_slot.rd_ok;

        out_d.rv    = lk_valid;
        out_d.hit   = lk_valid && m_hit && allowed;
        out_d.fault = lk_valid && m_hit && !allowed;
        out_d.miss  = lk_valid && !m_hit;
        if (out_d.hit) out_d.paddr = {m_slot.ppn, lk_vaddr[OFF_W-1:0]};

        if (fill_valid && sweep) begin
            for (int i = 0; i < ENTRIES; i++) slot_d[i].used = 1'b0;
        end

        if (out_d.hit) begin
            slot_d[m_idx].used = 1'b1;
            if (lk_write) slot_d[m_idx].dirty = 1'b1;
        end

        if (fill_valid) begin
            out_d.evv = slot_q[vic_idx].vld;
            out_d.evd = slot_q[vic_idx].vld && slot_q[vic_idx].dirty;
            out_d.evn = slot_q[vic_idx].vld ? slot_q[vic_idx].tag : '0;
            out_d.evs = vic_idx;
            slot_d[vic_idx] = '{vld: 1'b1, dirty: 1'b0, used: 1'b1,
                                rd_ok: fill_rd, wr_ok: fill_wr,
                                tag: fill_vpn, ppn: fill_ppn};
        end

        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) slot_d[i].vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) slot_q[i] <= '0;
            out_q <= '0;
        end else begin
            slot_q <= slot_d;
            out_q  <= out_d;
        end
    end

    assign res_valid = out_q.rv;
    assign res_hit   = out_q.hit;
    assign res_miss  = out_q.miss;
    assign res_fault = out_q.fault;
    assign res_paddr = out_q.paddr;
    assign ev_valid  = out_q.evv;
    assign ev_dirty  = out_q.evd;
    assign ev_vpn    = out_q.evn;
    assign ev_slot   = out_q.evs;

    // R1
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));
    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_hit, res_miss, res_fault}) == 1);
    // R3
    fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_fault |-> (res_paddr == '0) && !res_hit);
    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> vld_vec == '0);
    // R8
    sweep_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && sweep && !lk_valid && !flush) |=> used_vec == ENTRIES'(1));
    // R12
    evict_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_dirty |-> ev_valid);
endmodule

// File: tb/va_xlate_tlb_bench.sv
module va_xlate_tlb_bench;
    localparam int N = 8;
    localparam int IW = $clog2(N);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        fill_rd = 1'b0, fill_wr = 1'b0;
    logic        res_valid, res_hit, res_miss, res_fault;
    logic [31:0] res_paddr;
    logic        ev_valid, ev_dirty;
    logic [19:0] ev_vpn;
    logic [IW-1:0] ev_slot;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    va_xlate_tlb #(.ENTRIES(N)) u_va_xlate_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vaddr(lk_vaddr),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_rd(fill_rd), .fill_wr(fill_wr),
        .res_valid(res_valid), .res_hit(res_hit), .res_miss(res_miss),
        .res_fault(res_fault), .res_paddr(res_paddr),
        .ev_valid(ev_valid), .ev_dirty(ev_dirty), .ev_vpn(ev_vpn),
        .ev_slot(ev_slot)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // outcome encoding {hit, miss, fault}: 4 = hit, 2 = miss, 1 = fault
    task automatic lookup(input string req, input logic [19:0] vpn, input logic [11:0] off,
                          input logic wr, input logic [2:0] exp_o, input logic [31:0] exp_pa);
        lk_valid = 1'b1; lk_write = wr; lk_vaddr = {vpn, off};
        @(negedge clk);
        check(req, {res_valid, res_hit, res_miss, res_fault}, {1'b1, exp_o});
        check(req, res_paddr, exp_pa);
        lk_valid = 1'b0;
    endtask

    task automatic fill(input string req, input logic [19:0] vpn, input logic [19:0] ppn,
                        input logic rd, input logic wr, input int exp_slot,
                        input logic exp_ev, input logic exp_dirty, input logic [19:0] exp_vpn);
        fill_valid = 1'b1; fill_vpn = vpn; fill_ppn = ppn; fill_rd = rd; fill_wr = wr;
        @(negedge clk);
        check(req, ev_slot, exp_slot);
        check(req, {ev_valid, ev_dirty}, {exp_ev, exp_dirty});
        if (exp_ev) check(req, ev_vpn, exp_vpn);
        fill_valid = 1'b0;
    endtask

    function automatic logic rd_of(int i); return (i % 4 == 0) || (i % 4 == 1); endfunction
    function automatic logic wr_of(int i); return (i % 4 == 0) || (i % 4 == 2); endfunction
    function automatic logic [19:0] ppn_of(int i); return 20'h800 + 20'(i * 3); endfunction

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [11:0] offs [4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        check("R2 reset", {res_valid, res_hit, ev_valid}, 3'b000);
        lookup("R2 empty miss", 20'h10, 12'h123, 1'b0, 3'b010, 32'h0);

        // R6 R12 fill all slots while free
        for (int i = 0; i < N; i++)
            fill("R6 free slot", 20'h10 + 20'(i), ppn_of(i), rd_of(i), wr_of(i), i, 1'b0, 1'b0, 20'h0);

        // R1 R3 R4 sweep over slots, offsets and access types
        for (int i = 0; i < N; i++) begin
            offs[0] = 12'h000; offs[1] = 12'h7FF; offs[2] = 12'hFFF; offs[3] = 12'(i * 12'h123);
            for (int k = 0; k < 4; k++) begin
                for (int w = 0; w < 2; w++) begin
                    logic ok;
                    ok = (w == 1) ? wr_of(i) : rd_of(i);
                    lookup(w == 1 ? "R1 R4 write" : "R1 R3 read", 20'h10 + 20'(i), offs[k], w[0],
                           ok ? 3'b100 : 3'b001, ok ? {ppn_of(i), offs[k]} : 32'h0);
                end
            end
        end
        for (int i = 0; i < N; i++)
            lookup("R2 absent miss", 20'h20 + 20'(i), 12'h055, i[0], 3'b010, 32'h0);

        // R8 R5: all used marks set, slot 0 modified
        fill("R8 R5 sweep", 20'h40, 20'hABCDE, 1'b1, 1'b1, 0, 1'b1, 1'b1, 20'h10);
        // R11 faulting write and read on slot 3 leave marks alone
        lookup("R4 fault", 20'h13, 12'h001, 1'b1, 3'b001, 32'h0);
        lookup("R3 fault", 20'h13, 12'h002, 1'b0, 3'b001, 32'h0);
        // R9 read hit on slot 1 sets its used mark
        lookup("R9 hit", 20'h11, 12'h010, 1'b0, 3'b100, {ppn_of(1), 12'h010});
        fill("R7 R9 cold pick", 20'h41, 20'h11111, 1'b1, 1'b0, 2, 1'b1, 1'b1, 20'h12);
        fill("R11 R7 untouched", 20'h42, 20'h22222, 1'b1, 1'b1, 3, 1'b1, 1'b0, 20'h13);
        fill("R7 R5 next cold", 20'h43, 20'h33333, 1'b0, 1'b1, 4, 1'b1, 1'b1, 20'h14);
        lookup("R1 new map", 20'h40, 12'h5A5, 1'b0, 3'b100, {20'hABCDE, 12'h5A5});
        lookup("R2 evicted", 20'h10, 12'h5A5, 1'b0, 3'b010, 32'h0);

        // R10 flush
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        lookup("R10 after flush", 20'h40, 12'h000, 1'b0, 3'b010, 32'h0);
        lookup("R10 after flush", 20'h17, 12'h000, 1'b0, 3'b010, 32'h0);
        fill("R10 R12 refill", 20'h50, 20'h0BEEF, 1'b1, 1'b1, 0, 1'b0, 1'b0, 20'h0);
        lookup("R1 refill hit", 20'h50, 12'hC3C, 1'b1, 3'b100, {20'h0BEEF, 12'hC3C});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule